// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a windowed integer register file for a processor that passes procedure arguments through registers. Each procedure sees 32 registers of 32 bits. Registers 0 to 7 are globals and are the same storage whatever the window. Registers 8 to 31 come from the current window, which a window pointer selects. A save moves the pointer forward by one window on a call, and a restore moves it back on return.

Neighbouring windows share physical registers. The eight output registers of a caller are the same storage as the eight input registers of the procedure it calls. Arguments are therefore handed over by moving the pointer, with no copying. The windowed storage holds 16 registers per physical window: eight private locals and eight shared input/output registers. The pointer wraps around the physical windows.

Only a limited number of windows can be resident at once. A save that would run past them raises a one-cycle overflow flag, and a restore past the oldest resident window raises a one-cycle underflow flag. In both cases the pointer does not move. Spilling and filling windows to memory is left to software outside this block.

Top module: `regwin_file`

## Requirements
- R1: Visible register 0 always reads as zero, and a write to it has no effect on any register, including in the same cycle.
- R2: Visible registers 1 to 7 are globals. A value written to one is read back unchanged from every window.
- R3: After a save, the callee's registers 24 to 31 read the values the caller held in registers 8 to 15. After a restore, the caller's registers 8 to 15 read whatever the callee wrote to its registers 24 to 31.
- R4: Registers 16 to 23 are private to each window. A fresh window's locals do not show the caller's locals, and the caller's locals are intact after the matching restore.
- R5: A save that does not overflow adds one, modulo NWIN, to `win_ptr` at the next clock edge. A restore that does not underflow subtracts one, modulo NWIN. The window after NWIN-1 is window 0.
- R6: At most NWIN-2 saves can be outstanding beyond the reset window. A further save pulses `win_ovf` high for exactly one cycle, one cycle after the request, and leaves `win_ptr` unchanged.
- R7: A restore with no outstanding save pulses `win_unf` high for exactly one cycle, one cycle after the request, and leaves `win_ptr` unchanged.
- R8: A read of the physical register that the write port updates in the same cycle returns the new write data.
- R9: When `save_req` and `restore_req` are asserted together, the pointer does not move and neither flag rises.
- R10: After a synchronous reset, `win_ptr` equals START_WIN (default NWIN-2), both flags are low, and every register reads zero.
- R11: A write issued in the same cycle as a save or restore lands in the window that was current before the pointer moves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Visible register number for read port A |
| rd_a_data | output | XLEN | Read port A data (combinational) |
| rd_b_idx | input | 5 | Visible register number for read port B |
| rd_b_data | output | XLEN | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Visible register number to write |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Advance to the next window |
| restore_req | input | 1 | Return to the previous window |
| win_ptr | output | $clog2(NWIN) | Current window number |
| win_ovf | output | 1 | One-cycle pulse: save refused |
| win_unf | output | 1 | One-cycle pulse: restore refused |

## Verification
The hardest case to reach from the ports is a save that crosses the top physical window while resident windows are already at their limit. For that, the outs of the last window must map onto the ins of window 0, and the overflow refusal must happen in the very cycle the last free window is used up. The reset window is placed near the top of the range, so a short chain of saves crosses the wrap and then hits overflow. Writes ride along with the saves and restores and are read back after the return chain, which checks that nothing was copied or lost in the shared registers.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    localparam int NGLOB  = 8;
    localparam int WREGS  = 16;
    localparam int VIS_W  = 5;

    typedef enum logic [1:0] {
        WOP_NONE,
        WOP_SAVE,
        WOP_RESTORE,
        WOP_CLASH
    } win_op_e;

    typedef struct packed {
        logic ovf;
        logic unf;
    } win_evt_t;

    function automatic win_op_e decode_op(input logic s, input logic r);
        if (s && r)      return WOP_CLASH;
        else if (s)      return WOP_SAVE;
        else if (r)      return WOP_RESTORE;
        else             return WOP_NONE;
    endfunction

    // Visible register -> flat physical index.
    // Globals occupy 0..7; window w owns locals at base+0..7 and ins at base+8..15,
    // its outs are the ins of the following window.
    function automatic int phys_of(input int win, input logic [VIS_W-1:0] v, input int nwin);
        int off;
        off = int'(v[2:0]);
        case (v[4:3])
            2'd0:    return off;
            2'd1:    return NGLOB + ((win + 1) % nwin) * WREGS + 8 + off;
            2'd2:    return NGLOB + win * WREGS + off;
            default: return NGLOB + win * WREGS + 8 + off;
        endcase
    endfunction

endpackage

// File: rtl/rwin_map.sv
module rwin_map
    import rwin_pkg::*;
#(
    parameter int NWIN = 5,
    parameter int WPW  = $clog2(NWIN),
    parameter int PAW  = $clog2(NGLOB + WREGS * NWIN)
) (
    input  logic [WPW-1:0]   win,
    input  logic [VIS_W-1:0] vidx,
    output logic [PAW-1:0]   paddr
);

    assign paddr = PAW'(phys_of(int'(win), vidx, NWIN));

endmodule

// File: rtl/rwin_ptr.sv
module rwin_ptr
    import rwin_pkg::*;
#(
    parameter int NWIN      = 5,
    parameter int START_WIN = NWIN - 2,
    parameter int WPW       = $clog2(NWIN)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           save_req,
    input  logic           restore_req,
    output logic [WPW-1:0] win,
    output win_evt_t       evt
);

    localparam int DW = $clog2(NWIN);
    localparam logic [WPW-1:0] LAST  = WPW'(NWIN - 1);
    localparam logic [WPW-1:0] ONEW  = WPW'(1);
    localparam logic [WPW-1:0] INITW = WPW'(START_WIN);
    localparam logic [DW-1:0]  DMAX  = DW'(NWIN - 2);
    localparam logic [DW-1:0]  ONED  = DW'(1);

    logic [WPW-1:0] win_q;
    logic [DW-1:0]  depth_q;
    win_evt_t       evt_q;
    win_op_e        op;

    assign op = decode_op(save_req, restore_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q   <= INITW;
            depth_q <= '0;
            evt_q   <= '0;
        end else begin
            evt_q <= '0;
            case (op)
                WOP_SAVE: begin
                    if (depth_q == DMAX) begin
                        evt_q.ovf <= 1'b1;
                    end else begin
                        win_q   <= (win_q == LAST) ? '0 : win_q + ONEW;
                        depth_q <= depth_q + ONED;
                    end
                end
                WOP_RESTORE: begin
                    if (depth_q == '0) begin
                        evt_q.unf <= 1'b1;
                    end else begin
                        win_q   <= (win_q == '0) ? LAST : win_q - ONEW;
                        depth_q <= depth_q - ONED;
                    end
                end
                default: ;
            endcase
        end
    end

    assign win = win_q;
    assign evt = evt_q;

    // R5
    save_step_chk: assert property (@(posedge clk) disable iff (rst)
        (op == WOP_SAVE && depth_q != DMAX) |=>
            (depth_q == $past(depth_q) + ONED) && (win_q != $past(win_q)));

    // R5
    restore_step_chk: assert property (@(posedge clk) disable iff (rst)
        (op == WOP_RESTORE && depth_q != '0) |=>
            (depth_q == $past(depth_q) - ONED) && (win_q != $past(win_q)));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        evt_q.ovf |-> ($stable(win_q) && depth_q == DMAX && !evt_q.unf));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        evt_q.unf |-> ($stable(win_q) && depth_q == '0));

    // R9
    clash_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (op == WOP_CLASH) |=> ($stable(win_q) && !evt_q.ovf && !evt_q.unf));

endmodule

// File: rtl/rwin_store.sv
module rwin_store
    import rwin_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NPHYS = 88,
    parameter int PAW   = $clog2(NPHYS),
    parameter int NRD   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [PAW-1:0]            waddr,
    input  logic [XLEN-1:0]           wdata,
    input  logic [NRD-1:0][PAW-1:0]   raddr,
    output logic [NRD-1:0][XLEN-1:0]  rdata
);

    logic [XLEN-1:0] mem [NPHYS];
    logic            wfire;

    // physical slot 0 is the hard zero register
    assign wfire = we && (waddr != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else if (wfire) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (wfire && waddr == raddr[g]) ? wdata : mem[raddr[g]];
    end

    // R1
    zero_slot_chk: assert property (@(posedge clk) disable iff (rst)
        mem[0] == '0);

endmodule

// File: rtl/regwin_file.sv
module regwin_file
    import rwin_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int NWIN      = 5,
    parameter int START_WIN = NWIN - 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [VIS_W-1:0]         rd_a_idx,
    output logic [XLEN-1:0]          rd_a_data,
    input  logic [VIS_W-1:0]         rd_b_idx,
    output logic [XLEN-1:0]          rd_b_data,
    input  logic                     wr_en,
    input  logic [VIS_W-1:0]         wr_idx,
    input  logic [XLEN-1:0]          wr_data,
    input  logic                     save_req,
    input  logic                     restore_req,
    output logic [$clog2(NWIN)-1:0]  win_ptr,
    output logic                     win_ovf,
    output logic                     win_unf
);

    localparam int WPW   = $clog2(NWIN);
    localparam int NPHYS = NGLOB + WREGS * NWIN;
    localparam int PAW   = $clog2(NPHYS);
    localparam int NPORT = 3;   // two reads, one write

    logic [WPW-1:0]               win;
    win_evt_t                     evt;
    logic [NPORT-1:0][VIS_W-1:0]  vidx;
    logic [NPORT-1:0][PAW-1:0]    paddr;
    logic [1:0][XLEN-1:0]         rdata;

    assign vidx[0] = rd_a_idx;
    assign vidx[1] = rd_b_idx;
    assign vidx[2] = wr_idx;

    rwin_ptr #(
        .NWIN      (NWIN),
        .START_WIN (START_WIN),
        .WPW       (WPW)
    ) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .save_req    (save_req),
        .restore_req (restore_req),
        .win         (win),
        .evt         (evt)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rwin_map #(
            .NWIN (NWIN),
            .WPW  (WPW),
            .PAW  (PAW)
        ) u_map (
            .win   (win),
            .vidx  (vidx[p]),
            .paddr (paddr[p])
        );
    end

    rwin_store #(
        .XLEN  (XLEN),
        .NPHYS (NPHYS),
        .PAW   (PAW),
        .NRD   (2)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (paddr[2]),
        .wdata (wr_data),
        .raddr (paddr[1:0]),
        .rdata (rdata)
    );

    assign rd_a_data = rdata[0];
    assign rd_b_data = rdata[1];
    assign win_ptr   = win;
    assign win_ovf   = evt.ovf;
    assign win_unf   = evt.unf;

    // R1
    zero_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == '0) |-> (rd_a_data == '0));

    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(win_ovf && win_unf));

endmodule

// File: tb/regwin_file_test.sv
`timescale 1ns/1ps
module regwin_file_test;

    localparam int N     = 5;
    localparam int START = N - 2;
    localparam int MAXD  = N - 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
    logic        wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0;
    logic [2:0]  win_ptr;
    logic        win_ovf, win_unf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] mm [int];
    int mwin = START;
    int mdepth = 0;
    bit eovf = 0, eunf = 0;

    always #4 clk = ~clk;

    regwin_file #(.XLEN(32), .NWIN(N)) uut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .win_ptr(win_ptr), .win_ovf(win_ovf), .win_unf(win_unf)
    );

    // location key: globals, shared in/out groups, private locals
    function automatic int key(input int win, input int idx);
        int o;
        o = idx % 8;
        case (idx / 8)
            0:       return idx;
            1:       return 100 + ((win + 1) % N) * 8 + o;
            2:       return 1000 + win * 8 + o;
            default: return 100 + win * 8 + o;
        endcase
    endfunction

    function automatic logic [31:0] mread(input int ra, input bit we, input int wi, input logic [31:0] wd);
        int k;
        if (ra == 0) return '0;
        k = key(mwin, ra);
        if (we && wi != 0 && key(mwin, wi) == k) return wd;
        if (mm.exists(k)) return mm[k];
        return '0;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc(input string tag, input bit s, input bit r, input bit we,
                       input int wi, input logic [31:0] wd, input int ra, input int rb);
        save_req = s; restore_req = r; wr_en = we;
        wr_idx = wi[4:0]; wr_data = wd; rd_a_idx = ra[4:0]; rd_b_idx = rb[4:0];
        #1;
        chk(tag, "rd_a", rd_a_data, mread(ra, we, wi, wd));
        chk(tag, "rd_b", rd_b_data, mread(rb, we, wi, wd));
        @(posedge clk);
        if (we && wi != 0) mm[key(mwin, wi)] = wd;
        eovf = 0; eunf = 0;
        if (s && !r) begin
            if (mdepth == MAXD) eovf = 1;
            else begin mwin = (mwin + 1) % N; mdepth++; end
        end else if (r && !s) begin
            if (mdepth == 0) eunf = 1;
            else begin mwin = (mwin + N - 1) % N; mdepth--; end
        end
        @(negedge clk);
        chk(tag, "win_ptr", {29'd0, win_ptr}, mwin);
        chk(tag, "win_ovf", {31'd0, win_ovf}, {31'd0, eovf});
        chk(tag, "win_unf", {31'd0, win_unf}, {31'd0, eunf});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        chk("R10", "win_ptr", {29'd0, win_ptr}, START);
        chk("R10", "flags", {30'd0, win_ovf, win_unf}, 32'd0);
        for (int i = 0; i < 32; i += 2) cyc("R10", 0, 0, 0, 0, 0, i, i + 1);

        // R1: zero register ignores writes
        cyc("R1", 0, 0, 1, 0, 32'hDEAD_BEEF, 0, 0);
        cyc("R1", 0, 0, 0, 0, 0, 0, 0);

        // R8 + R2: globals written with bypass reads
        for (int i = 1; i < 8; i++) cyc("R8", 0, 0, 1, i, 32'h6100_0000 + i, i, 0);

        // fill the reset window: outs, locals, ins
        for (int i = 8; i < 32; i++) cyc("R8", 0, 0, 1, i, 32'hA300_0000 + i, i, (i + 3) % 32);

        // R11: write a local in the same cycle as the save
        cyc("R11", 1, 0, 1, 16, 32'h5A5A_0016, 16, 8);
        // R3: callee ins show caller outs; R4: fresh locals
        for (int i = 24; i < 32; i++) cyc("R3", 0, 0, 0, 0, 0, i, i - 8);
        for (int i = 1; i < 8; i++)  cyc("R2", 0, 0, 0, 0, 0, i, i);

        // callee writes its ins (return values) and outs
        for (int i = 24; i < 28; i++) cyc("R3", 0, 0, 1, i, 32'hB400_0000 + i, i, 8);
        for (int i = 8; i < 16; i++)  cyc("R5", 0, 0, 1, i, 32'hB400_0100 + i, i, 31);

        // R5: save across the top window, outs of last window wrap to window 0
        cyc("R5", 1, 0, 0, 0, 0, 24, 16);
        for (int i = 24; i < 32; i++) cyc("R5", 0, 0, 1, i - 16, 32'hC000_0000 + i, i, i - 16);
        cyc("R5", 1, 0, 0, 0, 0, 24, 8);
        cyc("R4", 0, 0, 1, 17, 32'hD000_0017, 17, 24);

        // R6: overflow at the resident limit, twice in a row
        cyc("R6", 1, 0, 0, 0, 0, 17, 25);
        cyc("R6", 1, 0, 1, 18, 32'hD000_0018, 18, 17);
        // R9: simultaneous requests
        cyc("R9", 1, 1, 0, 0, 0, 17, 18);
        cyc("R9", 0, 0, 0, 0, 0, 24, 3);

        // return chain
        cyc("R5", 0, 1, 1, 24, 32'hE000_0024, 24, 17);
        for (int i = 8; i < 16; i++) cyc("R3", 0, 0, 0, 0, 0, i, i + 16);
        cyc("R5", 0, 1, 0, 0, 0, 16, 8);
        cyc("R5", 0, 1, 0, 0, 0, 8, 9);
        // R4 + R11: caller locals intact, same-cycle write landed in this window
        for (int i = 16; i < 24; i++) cyc("R4", 0, 0, 0, 0, 0, i, i - 8);
        chk("R11", "win_ptr", {29'd0, win_ptr}, START);

        // R7: underflow with no outstanding save
        cyc("R7", 0, 1, 0, 0, 0, 16, 24);
        cyc("R7", 0, 1, 0, 0, 0, 1, 2);
        cyc("R9", 1, 1, 0, 0, 0, 16, 0);
        cyc("R1", 0, 0, 0, 0, 0, 0, 7);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule